// File: doc/BRIEF.md
# Dirty-Page Update Region Coalescer

This block walks the per-page dirty flags of a frame buffer from the top line to the bottom line. Each flag page holds four display lines. The block sends one query per flag to an external flag store and gets the answer back in the same cycle. It merges vertically adjacent dirty pages into runs and emits each run as an update rectangle that spans the full frame width. When the walk is over, it reports the single range of pages that holds every dirty page it saw, so that the store can clear that range.

The scan has two modes. In the indexed mode a page is judged by its 8-bit plane flag alone. In the deep mode a page is dirty when its 8-bit plane flag is set, or when any of the four direct-colour plane pages or any of the four control plane pages that belong to it is set. A force option treats every page as dirty and issues no queries. This gives the redraw that follows an invalidate of the whole frame. Rectangles leave on a valid/ready port, and the scan waits while that port is blocked.

Top module: `dirty_page_coalescer`

## Requirements
- R1: After reset, rect_valid_o, clr_valid_o, done_o and qry_valid_o are all low until a start pulse is given.
- R2: A scan of height H covers pages 0 to ceil(H/4)-1, and page p starts at line 4p. In indexed mode (deep_i=0) each page takes exactly one query, with plane code 0 and address p.
- R3: In deep mode (deep_i=1) each page takes nine queries: plane 0 at address p, then plane 1 (direct) at addresses 4p..4p+3, then plane 2 (control) at addresses 4p..4p+3. The page is dirty if any of the nine answers is 1. In indexed mode the flags of planes 1 and 2 have no effect.
- R4: A run of consecutive dirty pages from page a to page b that ends before the last page gives one rectangle with y = 4a and lines = 4(b-a+1). Rectangles come out in increasing y order.
- R5: A run that is still open after the last page gives a rectangle with lines = 4*ceil(H/4) - y.
- R6: While rect_valid_o is high and rect_ready_i is low, the rectangle fields do not change and no query is issued.
- R7: If any page was dirty, clr_valid_o is high in the same cycle as done_o, with clr_lo_o equal to the first dirty page and clr_hi_o equal to the last dirty page.
- R8: If no page was dirty, including the case H = 0, done_o pulses for one cycle with clr_valid_o low and no rectangle is emitted.
- R9: With force_i=1 no queries are issued, and the result is one rectangle at y = 0 with lines = 4*ceil(H/4), plus a clear range of 0 to ceil(H/4)-1.
- R10: A start pulse given while a scan is in progress is ignored and does not change that scan's results.
- R11: rect_w_o equals the frame width parameter (1024 by default) on every rectangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a scan |
| height_i | input | Y_W | Display height in lines, sampled at start |
| deep_i | input | 1 | Deep mode: also consult the direct and control planes |
| force_i | input | 1 | Treat every page as dirty without querying |
| qry_valid_o | output | 1 | A flag query is being made this cycle |
| qry_plane_o | output | 2 | Plane of the query: 0 index, 1 direct, 2 control |
| qry_addr_o | output | Y_W | Page address of the query within its plane |
| qry_dirty_i | input | 1 | Flag value for the current query, same cycle |
| rect_valid_o | output | 1 | Rectangle record valid |
| rect_ready_i | input | 1 | Consumer accepts the rectangle |
| rect_y_o | output | Y_W+1 | First line of the rectangle |
| rect_lines_o | output | Y_W+1 | Number of lines in the rectangle |
| rect_w_o | output | clog2(FRAME_W+1) | Rectangle width, always the full frame |
| clr_valid_o | output | 1 | Clear-range request, high with done_o |
| clr_lo_o | output | Y_W-2 | First page to clear |
| clr_hi_o | output | Y_W-2 | Last page to clear, inclusive |
| done_o | output | 1 | One-cycle pulse at the end of a scan |

## Verification
A run-open flag or run start that goes wrong appears at the rectangle port when the next clean page or the end of the scan is reached. The symptom is a split, merged or shifted rectangle, or one with a wrong line count, so it is caught within the scan it occurs in. An error in the query sub-step counter shows up at once as a wrong plane or address on the query port, and later as a page whose dirty state was misread. A fault in the min/max tracking is visible only at done_o, as a wrong or missing clear range. For that reason each scan is compared as a whole against a model that walks the same flag arrays, while the ready input is throttled at random.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2,
    ST_FIN  = 2'd3
  } dpc_state_e;

  localparam logic [1:0] PL_INDEX  = 2'd0;
  localparam logic [1:0] PL_DIRECT = 2'd1;
  localparam logic [1:0] PL_CTRL   = 2'd2;

  localparam int unsigned LINES_PER_PAGE = 4;
  localparam logic [3:0]  SUB_LAST_DEEP  = 4'd8;
endpackage

// File: rtl/dpc_qry_gen.sv
module dpc_qry_gen
  import dpc_pkg::*;
#(
  parameter int PG_W = 8
) (
  input  logic [PG_W-1:0] page_i,
  input  logic [3:0]      sub_i,
  output logic [1:0]      plane_o,
  output logic [PG_W+1:0] addr_o
);
  logic [1:0] quarter;

  // sub 1..4 -> 0..3 and sub 5..8 -> 0..3, modulo four
  assign quarter = sub_i[1:0] - 2'd1;

  always_comb begin
    if (sub_i == 4'd0) begin
      plane_o = PL_INDEX;
      addr_o  = {2'b00, page_i};
    end else begin
      plane_o = (sub_i <= 4'd4) ? PL_DIRECT : PL_CTRL;
      addr_o  = {page_i, quarter};
    end
  end
endmodule

// File: rtl/dpc_range_trk.sv
module dpc_range_trk #(
  parameter int PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            hit_i,
  input  logic [PG_W-1:0] page_i,
  output logic            any_o,
  output logic [PG_W-1:0] lo_o,
  output logic [PG_W-1:0] hi_o
);
  logic            any_d;
  logic [PG_W-1:0] lo_d, hi_d;

  always_comb begin
    any_d = any_o;
    lo_d  = lo_o;
    hi_d  = hi_o;
    if (clr_i) begin
      any_d = 1'b0;
    end else if (hit_i) begin
      any_d = 1'b1;
      hi_d  = page_i;
      if (!any_o) lo_d = page_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_o <= 1'b0;
      lo_o  <= '0;
      hi_o  <= '0;
    end else begin
      any_o <= any_d;
      lo_o  <= lo_d;
      hi_o  <= hi_d;
    end
  end

  AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (lo_o <= hi_o)); // R7
endmodule

// File: rtl/dirty_page_coalescer.sv
module dirty_page_coalescer
  import dpc_pkg::*;
#(
  parameter int Y_W     = 10,
  parameter int FRAME_W = 1024
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [Y_W-1:0]               height_i,
  input  logic                         deep_i,
  input  logic                         force_i,
  output logic                         qry_valid_o,
  output logic [1:0]                   qry_plane_o,
  output logic [Y_W-1:0]               qry_addr_o,
  input  logic                         qry_dirty_i,
  output logic                         rect_valid_o,
  input  logic                         rect_ready_i,
  output logic [Y_W:0]                 rect_y_o,
  output logic [Y_W:0]                 rect_lines_o,
  output logic [$clog2(FRAME_W+1)-1:0] rect_w_o,
  output logic                         clr_valid_o,
  output logic [Y_W-3:0]               clr_lo_o,
  output logic [Y_W-3:0]               clr_hi_o,
  output logic                         done_o
);
  localparam int YC_W = Y_W + 1;
  localparam int PG_W = Y_W - 2;
  localparam int W_W  = $clog2(FRAME_W + 1);
  localparam logic [YC_W-1:0] Y_STEP = YC_W'(LINES_PER_PAGE);

  dpc_state_e      state_q, state_d;
  logic [YC_W-1:0] y_q, y_d;
  logic [Y_W-1:0]  h_q, h_d;
  logic [3:0]      sub_q, sub_d;
  logic            acc_q, acc_d;
  logic            run_q, run_d;
  logic [YC_W-1:0] rs_q, rs_d;
  logic [YC_W-1:0] ry_q, ry_d;
  logic [YC_W-1:0] rl_q, rl_d;
  logic            deep_q, deep_d;
  logic            force_q, force_d;

  logic            at_end, page_eval, page_hit, trk_clr;
  logic [PG_W-1:0] page_cur;
  logic [3:0]      sub_last;
  logic            any_dirty;

  assign at_end    = (y_q >= {1'b0, h_q});
  assign page_cur  = y_q[Y_W-1:2];
  assign sub_last  = deep_q ? SUB_LAST_DEEP : 4'd0;
  assign page_eval = (state_q == ST_SCAN) && !at_end && (force_q || (sub_q == sub_last));
  assign page_hit  = force_q || acc_q || qry_dirty_i;
  assign trk_clr   = (state_q == ST_IDLE) && start_i;

  dpc_qry_gen #(.PG_W(PG_W)) u_qry (
    .page_i  (page_cur),
    .sub_i   (sub_q),
    .plane_o (qry_plane_o),
    .addr_o  (qry_addr_o)
  );

  dpc_range_trk #(.PG_W(PG_W)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (trk_clr),
    .hit_i  (page_eval && page_hit),
    .page_i (page_cur),
    .any_o  (any_dirty),
    .lo_o   (clr_lo_o),
    .hi_o   (clr_hi_o)
  );

  always_comb begin
    state_d = state_q;
    y_d     = y_q;
    h_d     = h_q;
    sub_d   = sub_q;
    acc_d   = acc_q;
    run_d   = run_q;
    rs_d    = rs_q;
    ry_d    = ry_q;
    rl_d    = rl_q;
    deep_d  = deep_q;
    force_d = force_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SCAN;
          y_d     = '0;
          h_d     = height_i;
          sub_d   = '0;
          acc_d   = 1'b0;
          run_d   = 1'b0;
          deep_d  = deep_i;
          force_d = force_i;
        end
      end
      ST_SCAN: begin
        if (at_end) begin
          if (run_q) begin
            ry_d    = rs_q;
            rl_d    = y_q - rs_q;
            run_d   = 1'b0;
            state_d = ST_EMIT;
          end else begin
            state_d = ST_FIN;
          end
        end else if (page_eval) begin
          sub_d = '0;
          acc_d = 1'b0;
          y_d   = y_q + Y_STEP;
          if (page_hit) begin
            if (!run_q) begin
              run_d = 1'b1;
              rs_d  = y_q;
            end
          end else if (run_q) begin
            ry_d    = rs_q;
            rl_d    = y_q - rs_q;
            run_d   = 1'b0;
            state_d = ST_EMIT;
          end
        end else begin
          sub_d = sub_q + 4'd1;
          acc_d = acc_q | qry_dirty_i;
        end
      end
      ST_EMIT: begin
        if (rect_ready_i) state_d = ST_SCAN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      y_q     <= '0;
      h_q     <= '0;
      sub_q   <= '0;
      acc_q   <= 1'b0;
      run_q   <= 1'b0;
      rs_q    <= '0;
      ry_q    <= '0;
      rl_q    <= '0;
      deep_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      state_q <= state_d;
      y_q     <= y_d;
      h_q     <= h_d;
      sub_q   <= sub_d;
      acc_q   <= acc_d;
      run_q   <= run_d;
      rs_q    <= rs_d;
      ry_q    <= ry_d;
      rl_q    <= rl_d;
      deep_q  <= deep_d;
      force_q <= force_d;
    end
  end

  assign qry_valid_o  = (state_q == ST_SCAN) && !at_end && !force_q;
  assign rect_valid_o = (state_q == ST_EMIT);
  assign rect_y_o     = ry_q;
  assign rect_lines_o = rl_q;
  assign rect_w_o     = W_W'(FRAME_W);
  assign done_o       = (state_q == ST_FIN);
  assign clr_valid_o  = done_o && any_dirty;

  AST_RECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rect_valid_o && !rect_ready_i) |=> (rect_valid_o && $stable(rect_y_o) && $stable(rect_lines_o))); // R6
  AST_NO_QRY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid_o |-> !qry_valid_o); // R6
  AST_RECT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid_o |-> ((rect_lines_o != '0) && (rect_lines_o[1:0] == 2'b00) && (rect_y_o[1:0] == 2'b00))); // R4
  AST_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid_o |-> (done_o && (clr_lo_o <= clr_hi_o))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_QRY_INDEX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid_o && !deep_q) |-> (qry_plane_o == PL_INDEX)); // R2
  AST_FORCE_NO_QRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && force_q) |-> !qry_valid_o); // R9
endmodule

// File: tb/dirty_page_coalescer_bench.sv
module dirty_page_coalescer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Y_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [Y_W-1:0] height = '0;
  logic deep = 1'b0, force_all = 1'b0;
  logic qry_valid, qry_dirty;
  logic [1:0] qry_plane;
  logic [Y_W-1:0] qry_addr;
  logic rect_valid, rect_ready = 1'b1;
  logic [Y_W:0] rect_y, rect_lines;
  logic [10:0] rect_w;
  logic clr_valid, done;
  logic [Y_W-3:0] clr_lo, clr_hi;

  logic d0 [0:255];
  logic d1 [0:1023];
  logic d2 [0:1023];

  int checks = 0, fails = 0, cycles = 0;
  int rdy_pct = 100;
  bit running = 0;
  int qcnt, stall_err, got_cnt, got_done, got_clr, got_lo, got_hi, bad_w;
  int got_y [0:255];
  int got_n [0:255];
  int exp_cnt, exp_any, exp_lo, exp_hi, exp_q;
  int exp_y [0:255];
  int exp_n [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  dirty_page_coalescer u_dirty_page_coalescer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .height_i(height),
    .deep_i(deep), .force_i(force_all),
    .qry_valid_o(qry_valid), .qry_plane_o(qry_plane), .qry_addr_o(qry_addr),
    .qry_dirty_i(qry_dirty),
    .rect_valid_o(rect_valid), .rect_ready_i(rect_ready),
    .rect_y_o(rect_y), .rect_lines_o(rect_lines), .rect_w_o(rect_w),
    .clr_valid_o(clr_valid), .clr_lo_o(clr_lo), .clr_hi_o(clr_hi), .done_o(done)
  );

  always_comb begin
    case (qry_plane)
      2'd0:    qry_dirty = d0[qry_addr[7:0]];
      2'd1:    qry_dirty = d1[qry_addr];
      2'd2:    qry_dirty = d2[qry_addr];
      default: qry_dirty = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    #1;
    rect_ready = (rdy_pct >= 100) || (($urandom % 100) < rdy_pct);
  end

  always @(negedge clk) begin
    cycles++;
    if (running) begin
      if (qry_valid) qcnt++;
      if (rect_valid && !rect_ready && qry_valid) stall_err++;
      if (rect_valid && rect_ready) begin
        if (got_cnt < 256) begin
          got_y[got_cnt] = int'(rect_y);
          got_n[got_cnt] = int'(rect_lines);
        end
        if (rect_w != 11'd1024) bad_w++;
        got_cnt++;
      end
      if (done) begin
        got_done++;
        got_clr = clr_valid;
        got_lo = int'(clr_lo);
        got_hi = int'(clr_hi);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_flags();
    for (int i = 0; i < 256; i++) d0[i] = 1'b0;
    for (int i = 0; i < 1024; i++) begin d1[i] = 1'b0; d2[i] = 1'b0; end
  endtask

  task automatic model(input int h, input bit dp, input bit fc);
    int pages, start_y;
    bit open;
    pages = (h + 3) / 4;
    exp_cnt = 0; exp_any = 0; exp_lo = 0; exp_hi = 0; open = 0; start_y = 0;
    exp_q = fc ? 0 : (dp ? 9 * pages : pages);
    for (int p = 0; p < pages; p++) begin
      bit dirty;
      dirty = fc || d0[p];
      if (dp) for (int k = 0; k < 4; k++) dirty = dirty || d1[4*p+k] || d2[4*p+k];
      if (dirty) begin
        if (!exp_any) exp_lo = p;
        exp_hi = p; exp_any = 1;
        if (!open) begin open = 1; start_y = 4 * p; end
      end else if (open) begin
        exp_y[exp_cnt] = start_y; exp_n[exp_cnt] = 4 * p - start_y; exp_cnt++; open = 0;
      end
    end
    if (open) begin
      exp_y[exp_cnt] = start_y; exp_n[exp_cnt] = 4 * pages - start_y; exp_cnt++;
    end
  endtask

  task automatic run_scan(input int h, input bit dp, input bit fc, input int rp,
                          input bit restart, input string req);
    int wait_c;
    model(h, dp, fc);
    rdy_pct = rp;
    qcnt = 0; stall_err = 0; got_cnt = 0; got_done = 0; got_clr = 0; bad_w = 0;
    @(negedge clk);
    height = Y_W'(h); deep = dp; force_all = fc; start = 1'b1;
    running = 1;
    @(negedge clk);
    start = 1'b0;
    wait_c = 0;
    while (got_done == 0 && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
      if (restart && wait_c == 20) begin
        start = 1'b1; height = Y_W'(4); deep = ~dp; force_all = ~fc;
      end
      if (restart && wait_c == 21) start = 1'b0;
    end
    @(negedge clk);
    running = 0;
    check(got_done == 1, req, "done pulses", got_done, 1);
    check(got_cnt == exp_cnt, req, "rect count", got_cnt, exp_cnt);
    for (int i = 0; i < exp_cnt && i < got_cnt; i++) begin
      check(got_y[i] == exp_y[i], req, "rect y", got_y[i], exp_y[i]);
      check(got_n[i] == exp_n[i], req, "rect lines", got_n[i], exp_n[i]);
    end
    check(bad_w == 0, "R11", "rect width errors", bad_w, 0);
    check(got_clr == exp_any, exp_any ? "R7" : "R8", "clear valid", got_clr, exp_any);
    if (exp_any) begin
      check(got_lo == exp_lo, "R7", "clear lo", got_lo, exp_lo);
      check(got_hi == exp_hi, "R7", "clear hi", got_hi, exp_hi);
    end
    check(qcnt == exp_q, dp ? "R3" : "R2", "query count", qcnt, exp_q);
    check(stall_err == 0, "R6", "queries while stalled", stall_err, 0);
  endtask

  initial begin
    int junk;
    junk = int'($urandom(32'd5150));
    clear_flags();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rect_valid && !done && !qry_valid && !clr_valid, "R1", "outputs idle in reset",
          int'({rect_valid, done, qry_valid, clr_valid}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rect_valid && !done && !qry_valid && !clr_valid, "R1", "outputs idle after reset",
          int'({rect_valid, done, qry_valid, clr_valid}), 0);

    // R8 / R2: all clean, full height
    run_scan(768, 0, 0, 100, 0, "R8");
    // R8: zero height
    run_scan(0, 1, 0, 100, 0, "R8");
    // R4: interior runs
    d0[2] = 1; d0[3] = 1; d0[4] = 1; d0[10] = 1;
    run_scan(768, 0, 0, 100, 0, "R4");
    // R5: run open at end, partial last page
    clear_flags(); d0[191] = 1; d0[192] = 1;
    run_scan(770, 0, 0, 100, 0, "R5");
    // R3: deep plane pages only
    clear_flags(); d2[23] = 1; d1[28] = 1;
    run_scan(768, 1, 0, 100, 0, "R3");
    // R3: same flags are ignored in indexed mode
    run_scan(768, 0, 0, 100, 0, "R3");
    // R9: force all pages
    run_scan(100, 0, 1, 100, 0, "R9");
    run_scan(1023, 1, 1, 40, 0, "R9");
    // R6: alternating pages with heavy backpressure
    clear_flags();
    for (int p = 0; p < 256; p += 2) d0[p] = 1;
    run_scan(1000, 0, 0, 20, 0, "R6");
    // R10: start while busy ignored
    run_scan(768, 0, 0, 60, 1, "R10");

    // randomized scans
    for (int t = 0; t < 20; t++) begin
      int dens;
      clear_flags();
      dens = int'($urandom % 60);
      for (int i = 0; i < 256; i++) d0[i] = (($urandom % 100) < dens);
      for (int i = 0; i < 1024; i++) begin
        d1[i] = (($urandom % 400) < dens);
        d2[i] = (($urandom % 400) < dens);
      end
      run_scan(int'($urandom % 1024), ($urandom % 2) == 1, ($urandom % 8) == 0,
               30 + int'($urandom % 71), 0, "R4");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule